// File: doc/BRIEF.md
# Three-Wire Serial Register Slave

This block terminates a three-wire serial control link: an active-low chip select, a serial clock driven by the host, and one bidirectional data line. The block splits that line into an input, an output and an output enable. Each frame carries sixteen bits, most significant first: a two-bit command, a six-bit register address and an eight-bit data byte. The slave decodes write, read and master-reset commands against a bank of 8-bit registers. A read does not answer inside the frame that requested it. It arms the data line so that the slave drives the selected byte during the following chip-select frame.

All three pins are oversampled in the system clock domain through synchronizers, and edges are found by comparing consecutive samples. The bank holds a power-enable register and a control register. The control register carries a deep-sleep override and two calibration-request bits. When the calibration engines report completion, each request bit clears itself and a sticky done flag is set. A read-only status register combines three live status inputs with the two done flags. A master-reset command returns the whole bank to its power-on state and keeps it there while chip select stays high. The slave also raises a flag whenever the data line is free of any pending or active read return.

Top module: `trio_reg_slave`

## Requirements
- R1: Out of reset, dio_oe is 0, dio_free is 1, pwr_en is 0, both calibration requests are 0, and every register reads back 0.
- R2: Data is sampled on rising serial-clock edges, most significant bit first, as command[1:0], address[5:0], data[7:0]. Command 2'b01 writes the data byte to the addressed register on the 16th rising edge, and reading it back returns the same byte.
- R3: After a read frame (command 2'b10), the next chip-select frame has dio_oe high for its whole length. dio_out presents the addressed byte, most significant bit first, and advances after each falling serial-clock edge. The host may clock 8 or 16 cycles, and bits 9 to 16 read 0.
- R4: dio_oe is 0 outside a read-return frame. Serial input clocked in during a read-return frame is not decoded, so a write pattern sent there changes no register.
- R5: A frame in which chip select rises before the 16th rising edge is discarded and changes no register.
- R6: Command 2'b00 has no effect on any register.
- R7: Command 2'b11 resets every register and both done flags to 0. The reset holds while chip select stays high after the frame, so completion pulses that arrive during that time are lost and pwr_en reads 0.
- R8: Address 0x1A reads as status: bit 7 pll_lock, bit 6 gain_state, bit 5 clk_alive, bits 4..2 zero, bit 1 polling-calibration done, bit 0 FSK-calibration done. Writes to 0x1A are ignored.
- R9: In register 0x01, bit 3 is the polling-calibration request and bit 2 the FSK-calibration request, both driven on pcal_req and fcal_req. A pulse on pcal_done_evt or fcal_done_evt clears the matching request bit and sets the matching done flag. Writing 1 to a request bit clears its done flag.
- R10: While bit 0 of register 0x01 (sleep) is 1, pwr_en is 0 and deep_sleep is 1. Otherwise pwr_en equals register 0x00. The sleep bit does not change the stored value of register 0x00.
- R11: dio_free is 1 while chip select is high and no read return is pending. It is 0 from the end of a read frame until the read-return frame ends.
- R12: Addresses 0x20 and above read 0, and writes to them are dropped without aliasing onto lower registers. Address 0x1F is an ordinary read/write register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock from the host |
| dio_in | input | 1 | Serial data line, input side |
| dio_out | output | 1 | Serial data line, output side |
| dio_oe | output | 1 | Output enable for the data line pad |
| dio_free | output | 1 | Data line idle with no read return owed |
| pll_lock | input | 1 | Live status bit 7 |
| gain_state | input | 1 | Live status bit 6 |
| clk_alive | input | 1 | Live status bit 5 |
| pcal_done_evt | input | 1 | One-cycle pulse: polling calibration finished |
| fcal_done_evt | input | 1 | One-cycle pulse: FSK calibration finished |
| pwr_en | output | 8 | Effective power enables after the sleep override |
| deep_sleep | output | 1 | Sleep override active |
| pcal_req | output | 1 | Polling-calibration request bit |
| fcal_req | output | 1 | FSK-calibration request bit |

## Verification
Writes are tried with complementary bit patterns (0xA5/0x5A), all-ones and all-zeros at the bottom, the middle and the top valid address. This separates a correct shift order and address decode from bit reversal, stuck bits and address aliasing. Frames cut short at 12 and 15 bits, a 2'b00 command, and a write pattern injected during a read return must all leave a known register unchanged. This separates discarding a frame from executing it on a partial or masked word. Read returns are clocked with both 8 and 16 cycles, so trailing zeros and a stable output enable are seen. Calibration and master-reset sequences interleave completion pulses with request writes and with the held reset, which separates sticky, self-clearing and held-reset behaviour.

// File: rtl/trio_pkg.sv
package trio_pkg;

    localparam int CMD_W     = 2;
    localparam int ADDR_W    = 6;
    localparam int DATA_W    = 8;
    localparam int FRAME_LEN = CMD_W + ADDR_W + DATA_W;

    localparam logic [ADDR_W-1:0] ADDR_PWR    = 6'h00;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 6'h01;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 6'h1A;

    localparam int BIT_SLEEP = 0;
    localparam int BIT_FCAL  = 2;
    localparam int BIT_PCAL  = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP  = 2'b00,
        CMD_WR   = 2'b01,
        CMD_RD   = 2'b10,
        CMD_MRST = 2'b11
    } cmd_e;

    typedef struct packed {
        logic                valid;
        cmd_e                cmd;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
    } frame_op_t;

    typedef struct packed {
        logic pll_lock;
        logic gain;
        logic clk_alive;
    } live_stat_t;

    function automatic logic [DATA_W-1:0] pack_status(live_stat_t s, logic pdone, logic fdone);
        return {s.pll_lock, s.gain, s.clk_alive, 3'b000, pdone, fdone};
    endfunction

endpackage

// File: rtl/trio_sync.sv
module trio_sync #(
    parameter int                 WIDTH   = 1,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/trio_frame_rx.sv
module trio_frame_rx
    import trio_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cs_act,
    input  logic      sclk_rise,
    input  logic      dio_bit,
    input  logic      mask,
    output frame_op_t op
);
    localparam int CNT_W = $clog2(FRAME_LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);

    logic [CNT_W-1:0]     bit_cnt;
    logic [FRAME_LEN-1:0] shreg;
    logic [FRAME_LEN-1:0] word_next;

    assign word_next = {shreg[FRAME_LEN-2:0], dio_bit};

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            shreg   <= '0;
            op      <= '0;
        end else begin
            op.valid <= 1'b0;
            if (!cs_act) begin
                bit_cnt <= '0;
            end else if (sclk_rise && bit_cnt != CNT_FULL) begin
                shreg   <= word_next;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_LAST && !mask) begin
                    op <= '{valid: 1'b1,
                            cmd:   cmd_e'(word_next[FRAME_LEN-1 -: CMD_W]),
                            addr:  word_next[DATA_W +: ADDR_W],
                            data:  word_next[DATA_W-1:0]};
                end
            end
        end
    end
endmodule

// File: rtl/trio_regbank.sv
module trio_regbank
    import trio_pkg::*;
#(
    parameter int NUM_REGS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  live_stat_t        live,
    input  logic              pcal_evt,
    input  logic              fcal_evt,
    output logic [DATA_W-1:0] pwr_reg,
    output logic              sleep_bit,
    output logic              pcal_bit,
    output logic              fcal_bit
);
    logic [DATA_W-1:0] regs [NUM_REGS];
    logic              pcal_done;
    logic              fcal_done;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
            pcal_done <= 1'b0;
            fcal_done <= 1'b0;
        end else begin
            if (pcal_evt) begin
                regs[ADDR_CTRL][BIT_PCAL] <= 1'b0;
                pcal_done                 <= 1'b1;
            end
            if (fcal_evt) begin
                regs[ADDR_CTRL][BIT_FCAL] <= 1'b0;
                fcal_done                 <= 1'b1;
            end
            if (wr_en) begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (addr == ADDR_W'(i) && ADDR_W'(i) != ADDR_STATUS) regs[i] <= wr_data;
                end
                if (addr == ADDR_CTRL && wr_data[BIT_PCAL]) pcal_done <= 1'b0;
                if (addr == ADDR_CTRL && wr_data[BIT_FCAL]) fcal_done <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (addr == ADDR_STATUS) begin
            rd_data = pack_status(live, pcal_done, fcal_done);
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (addr == ADDR_W'(i)) rd_data = regs[i];
            end
        end
    end

    assign pwr_reg   = regs[ADDR_PWR];
    assign sleep_bit = regs[ADDR_CTRL][BIT_SLEEP];
    assign pcal_bit  = regs[ADDR_CTRL][BIT_PCAL];
    assign fcal_bit  = regs[ADDR_CTRL][BIT_FCAL];
endmodule

// File: rtl/trio_reg_slave.sv
module trio_reg_slave
    import trio_pkg::*;
#(
    parameter int NUM_REGS    = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        sclk,
    input  logic        dio_in,
    output logic        dio_out,
    output logic        dio_oe,
    output logic        dio_free,
    input  logic        pll_lock,
    input  logic        gain_state,
    input  logic        clk_alive,
    input  logic        pcal_done_evt,
    input  logic        fcal_done_evt,
    output logic [7:0]  pwr_en,
    output logic        deep_sleep,
    output logic        pcal_req,
    output logic        fcal_req
);
    logic [2:0] pins_s;
    logic       cs_s, sclk_s, dio_s;
    logic       cs_q, sclk_q;
    logic       sclk_rise, sclk_fall, cs_fall, cs_rise;

    trio_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, dio_in}),
        .q   (pins_s)
    );
    assign {cs_s, sclk_s, dio_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    assign sclk_rise = sclk_s & ~sclk_q;
    assign sclk_fall = ~sclk_s & sclk_q;
    assign cs_fall   = ~cs_s & cs_q;
    assign cs_rise   = cs_s & ~cs_q;

    frame_op_t         op;
    logic              rd_frame;
    logic              rd_pending;
    logic              mrst_armed;
    logic              hold;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] rd_latch;
    logic [DATA_W-1:0] rd_shift;
    logic [DATA_W-1:0] pwr_reg;
    logic              sleep_bit;

    trio_frame_rx i_rx (
        .clk       (clk),
        .rst       (rst),
        .cs_act    (~cs_s),
        .sclk_rise (sclk_rise),
        .dio_bit   (dio_s),
        .mask      (rd_frame),
        .op        (op)
    );

    assign wr_en = op.valid && (op.cmd == CMD_WR);
    assign hold  = mrst_armed & cs_s;

    trio_regbank #(.NUM_REGS(NUM_REGS)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .hold      (hold),
        .wr_en     (wr_en),
        .addr      (op.addr),
        .wr_data   (op.data),
        .rd_data   (rd_data),
        .live      ('{pll_lock: pll_lock, gain: gain_state, clk_alive: clk_alive}),
        .pcal_evt  (pcal_done_evt),
        .fcal_evt  (fcal_done_evt),
        .pwr_reg   (pwr_reg),
        .sleep_bit (sleep_bit),
        .pcal_bit  (pcal_req),
        .fcal_bit  (fcal_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_frame   <= 1'b0;
            rd_pending <= 1'b0;
            rd_latch   <= '0;
            rd_shift   <= '0;
            mrst_armed <= 1'b0;
        end else begin
            if (cs_fall) begin
                mrst_armed <= 1'b0;
                if (rd_pending) begin
                    rd_frame   <= 1'b1;
                    rd_pending <= 1'b0;
                    rd_shift   <= rd_latch;
                end
            end else if (cs_rise) begin
                rd_frame <= 1'b0;
            end else if (rd_frame && sclk_fall) begin
                rd_shift <= {rd_shift[DATA_W-2:0], 1'b0};
            end
            if (op.valid && op.cmd == CMD_RD) begin
                rd_pending <= 1'b1;
                rd_latch   <= rd_data;
            end
            if (op.valid && op.cmd == CMD_MRST) mrst_armed <= 1'b1;
        end
    end

    assign dio_oe     = rd_frame;
    assign dio_out    = rd_frame & rd_shift[DATA_W-1];
    assign dio_free   = cs_s & ~rd_pending & ~rd_frame;
    assign deep_sleep = sleep_bit;
    assign pwr_en     = sleep_bit ? '0 : pwr_reg;
endmodule

// File: rtl/trio_reg_slave_chk.sv
module trio_reg_slave_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_s,
    input logic       dio_oe,
    input logic       dio_free,
    input logic       rd_pending,
    input logic       fcal_done_evt,
    input logic       wr_en,
    input logic       hold,
    input logic       fcal_req,
    input logic       pcal_req,
    input logic [7:0] pwr_en,
    input logic       op_valid
);
    logic cs_seen;

    always_ff @(posedge clk) begin
        if (rst) cs_seen <= 1'b1;
        else     cs_seen <= cs_s;
    end

    // R4
    oe_outside_frame_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_s && cs_seen) |-> !dio_oe);

    // R11
    free_vs_drive_chk: assert property (@(posedge clk) disable iff (rst)
        dio_oe |-> !dio_free);

    // R3
    return_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dio_oe) |-> $past(rd_pending));

    // R9
    fcal_selfclear_chk: assert property (@(posedge clk) disable iff (rst)
        (fcal_done_evt && !hold && !wr_en) |=> !fcal_req);

    // R7
    held_reset_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> (pwr_en == 8'h00) && !pcal_req && !fcal_req);

    // R2
    one_op_per_frame_chk: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);
endmodule

bind trio_reg_slave trio_reg_slave_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .cs_s          (cs_s),
    .dio_oe        (dio_oe),
    .dio_free      (dio_free),
    .rd_pending    (rd_pending),
    .fcal_done_evt (fcal_done_evt),
    .wr_en         (wr_en),
    .hold          (hold),
    .fcal_req      (fcal_req),
    .pcal_req      (pcal_req),
    .pwr_en        (pwr_en),
    .op_valid      (op.valid)
);

// File: tb/test_trio_reg_slave.sv
module test_trio_reg_slave;
    localparam int HALF = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, sclk = 1'b0, dio_in = 1'b0;
    logic       dio_out, dio_oe, dio_free;
    logic       pll_lock = 1'b1, gain_state = 1'b0, clk_alive = 1'b1;
    logic       pcal_done_evt = 1'b0, fcal_done_evt = 1'b0;
    logic [7:0] pwr_en;
    logic       deep_sleep, pcal_req, fcal_req;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    trio_reg_slave i_trio_reg_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .dio_in(dio_in),
        .dio_out(dio_out), .dio_oe(dio_oe), .dio_free(dio_free),
        .pll_lock(pll_lock), .gain_state(gain_state), .clk_alive(clk_alive),
        .pcal_done_evt(pcal_done_evt), .fcal_done_evt(fcal_done_evt),
        .pwr_en(pwr_en), .deep_sleep(deep_sleep), .pcal_req(pcal_req), .fcal_req(fcal_req)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Generic frame: drives 'drive' MSB first for nbits cycles, captures dio_out before each rise.
    task automatic frame(logic [15:0] drive, int nbits, output logic [15:0] got, output bit oe_all);
        got = '0;
        oe_all = 1'b1;
        tick(HALF);
        cs_n = 1'b0;
        dio_in = drive[15];
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            got[15-i] = dio_out;
            if (dio_oe !== 1'b1) oe_all = 1'b0;
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
            dio_in = (i < 15) ? drive[14-i] : 1'b0;
            tick(HALF);
        end
        dio_in = 1'b0;
        cs_n = 1'b1;
        tick(2*HALF);
    endtask

    task automatic send(logic [15:0] word, int nbits);
        logic [15:0] g;
        bit o;
        frame(word, nbits, g, o);
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        send({2'b01, a, d}, 16);
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] v);
        logic [15:0] g;
        bit o;
        send({2'b10, a, 8'h00}, 16);
        frame(16'h0000, 8, g, o);
        v = g[15:8];
    endtask

    task automatic pulse_fcal();
        fcal_done_evt = 1'b1; tick(1); fcal_done_evt = 1'b0; tick(3);
    endtask

    task automatic pulse_pcal();
        pcal_done_evt = 1'b1; tick(1); pcal_done_evt = 1'b0; tick(3);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1", "dio_oe", 16'(dio_oe), 16'h0);
        chk("R1", "dio_free", 16'(dio_free), 16'h1);
        chk("R1", "pwr_en", 16'(pwr_en), 16'h0);
        chk("R1", "cal reqs", 16'({pcal_req, fcal_req}), 16'h0);
        rd(6'h03, v);
        chk("R1", "reg03", 16'(v), 16'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] v;
        wr(6'h00, 8'hA5); rd(6'h00, v); chk("R2", "reg00 A5", 16'(v), 16'hA5);
        wr(6'h03, 8'h5A); rd(6'h03, v); chk("R2", "reg03 5A", 16'(v), 16'h5A);
        wr(6'h10, 8'hFF); rd(6'h10, v); chk("R2", "reg10 FF", 16'(v), 16'hFF);
        wr(6'h10, 8'h00); rd(6'h10, v); chk("R2", "reg10 00", 16'(v), 16'h00);
        rd(6'h00, v); chk("R2", "reg00 kept", 16'(v), 16'hA5);
    endtask

    task automatic t_read16();
        logic [15:0] g;
        bit o;
        send({2'b10, 6'h03, 8'h00}, 16);
        chk("R11", "free while pending", 16'(dio_free), 16'h0);
        chk("R4", "oe between frames", 16'(dio_oe), 16'h0);
        frame(16'h0000, 16, g, o);
        chk("R3", "16-cycle return", g, 16'h5A00);
        chk("R3", "oe whole frame", 16'(o), 16'h1);
        chk("R11", "free after return", 16'(dio_free), 16'h1);
        chk("R4", "oe after return", 16'(dio_oe), 16'h0);
    endtask

    task automatic t_return_ignores_input();
        logic [15:0] g;
        logic [7:0] v;
        bit o;
        send({2'b10, 6'h00, 8'h00}, 16);
        frame({2'b01, 6'h04, 8'hC3}, 16, g, o);
        chk("R3", "return of reg00", g, 16'hA500);
        rd(6'h04, v);
        chk("R4", "reg04 untouched", 16'(v), 16'h00);
    endtask

    task automatic t_short_and_nop();
        logic [7:0] v;
        wr(6'h02, 8'h11);
        send({2'b01, 6'h02, 8'h77}, 12);
        rd(6'h02, v); chk("R5", "12-bit frame", 16'(v), 16'h11);
        send({2'b01, 6'h02, 8'h77}, 15);
        rd(6'h02, v); chk("R5", "15-bit frame", 16'(v), 16'h11);
        send({2'b00, 6'h02, 8'h99}, 16);
        rd(6'h02, v); chk("R6", "nop cmd", 16'(v), 16'h11);
    endtask

    task automatic t_calibration();
        logic [7:0] v;
        wr(6'h01, 8'h0C);
        chk("R9", "both reqs set", 16'({pcal_req, fcal_req}), 16'h3);
        rd(6'h1A, v); chk("R8", "status no done", 16'(v), 16'hA0);
        pulse_fcal();
        chk("R9", "fcal cleared", 16'({pcal_req, fcal_req}), 16'h2);
        rd(6'h01, v); chk("R9", "ctrl after fcal", 16'(v), 16'h08);
        rd(6'h1A, v); chk("R8", "status fdone", 16'(v), 16'hA1);
        pulse_pcal();
        rd(6'h01, v); chk("R9", "ctrl after pcal", 16'(v), 16'h00);
        rd(6'h1A, v); chk("R8", "status both done", 16'(v), 16'hA3);
        wr(6'h01, 8'h04);
        rd(6'h1A, v); chk("R9", "fcal rerequest clears done", 16'(v), 16'hA2);
        pulse_fcal();
        gain_state = 1'b1;
        rd(6'h1A, v); chk("R8", "status gain", 16'(v), 16'hE3);
    endtask

    task automatic t_sleep();
        logic [7:0] v;
        wr(6'h00, 8'h3C); wr(6'h01, 8'h00);
        chk("R10", "pwr awake", 16'(pwr_en), 16'h3C);
        wr(6'h01, 8'h01);
        chk("R10", "pwr asleep", 16'(pwr_en), 16'h00);
        chk("R10", "deep_sleep", 16'(deep_sleep), 16'h1);
        rd(6'h00, v); chk("R10", "reg00 kept", 16'(v), 16'h3C);
        wr(6'h01, 8'h00);
        chk("R10", "pwr wake", 16'(pwr_en), 16'h3C);
    endtask

    task automatic t_master_reset();
        logic [7:0] v;
        wr(6'h01, 8'h08);
        send({2'b11, 14'h0000}, 16);
        chk("R7", "pwr in hold", 16'(pwr_en), 16'h00);
        chk("R7", "reqs in hold", 16'({pcal_req, fcal_req}), 16'h0);
        pulse_fcal();
        pulse_pcal();
        rd(6'h1A, v); chk("R7", "done lost in hold", 16'(v), 16'hE0);
        rd(6'h00, v); chk("R7", "reg00 reset", 16'(v), 16'h00);
        rd(6'h03, v); chk("R7", "reg03 reset", 16'(v), 16'h00);
        wr(6'h1A, 8'hFF);
        rd(6'h1A, v); chk("R8", "status write ignored", 16'(v), 16'hE0);
    endtask

    task automatic t_range();
        logic [7:0] v;
        wr(6'h1F, 8'h81); rd(6'h1F, v); chk("R12", "reg1F", 16'(v), 16'h81);
        wr(6'h25, 8'hFF); rd(6'h25, v); chk("R12", "reg25", 16'(v), 16'h00);
        rd(6'h05, v); chk("R12", "no alias 05", 16'(v), 16'h00);
    endtask

    initial begin
        tick(6);
        rst = 1'b0;
        tick(10);
        t_reset();
        t_write_read();
        t_read16();
        t_return_ignores_input();
        t_short_and_nop();
        t_calibration();
        t_sleep();
        t_master_reset();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule